// File: doc/BRIEF.md
# Maintenance Message Persistence Validator

This block sits behind the line receiver of a digital subscriber loop transceiver. Once every half superframe it is handed one pre-extracted 8-bit embedded operations channel (eoc) message and a group of activation indicator bits, together with a single-cycle strobe. From these it decides when to update the message register that the host reads, and when to pulse an interrupt.

A 2-bit policy input sets how much persistence a message needs before it is reported:

- **Transparent:** every strobe is reported.
- **Change-only:** a message is reported once, on the strobe where it differs from the last reported one.
- **Two or three in a row:** a new message must arrive identically two or three times in a row before it is reported.

A candidate register and a saturating repeat counter track the pending message. Any mismatch restarts the count, with the new value as the candidate. A change of policy also restarts the count.

The activation indicators are filtered one bit at a time under a fixed rule, whatever the policy. A new level is taken only after it has been received three times in a row. The filtered levels feed the activation decoder and can be read back, and they never raise an interrupt.

Top module: `maint_msg_validator`

## Requirements
- R1: After reset, msg_reg_o is 0, msg_irq_o is 0 and act_o is 0. The candidate and repeat counters start cleared.
- R2: With mode_i = 2'b00, every strobe pulses msg_irq_o and copies msg_i into msg_reg_o. This holds even when msg_i equals the stored value.
- R3: With mode_i = 2'b01, a strobe pulses msg_irq_o and loads msg_i only when msg_i differs from msg_reg_o. Otherwise nothing changes.
- R4: With mode_i = 2'b10, a value differing from msg_reg_o is reported on the second identical consecutive strobe, and not earlier.
- R5: With mode_i = 2'b11, a value differing from msg_reg_o is reported on the third identical consecutive strobe, and not earlier.
- R6: A strobe whose message differs from the pending candidate restarts the count at one, with that message as the new candidate.
- R7: msg_irq_o goes high in the clock cycle after the strobe edge and lasts one cycle. msg_reg_o changes only in a cycle where msg_irq_o is high.
- R8: A change of mode_i clears the repeat count. The next strobe then counts as the first reception under the new policy.
- R9: Each of the ACT_W activation bits is filtered on its own. act_o[i] takes a new level only on the third consecutive strobe carrying that level on act_i[i], whatever the value of mode_i.
- R10: A change of act_o never raises msg_irq_o.
- R11: When hsf_stb_i is low, msg_i and act_i are ignored: msg_reg_o, act_o and msg_irq_o stay unchanged or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsf_stb_i | input | 1 | Half-superframe strobe, one cycle wide |
| mode_i | input | 2 | Message policy: 00 transparent, 01 change-only, 10 two in a row, 11 three in a row |
| msg_i | input | MSG_W (8) | Received eoc message, valid with the strobe |
| act_i | input | ACT_W (4) | Raw activation indicator bits, valid with the strobe |
| msg_reg_o | output | MSG_W (8) | Reported message register |
| msg_irq_o | output | 1 | One-cycle interrupt pulse when a message is reported |
| act_o | output | ACT_W (4) | Filtered activation bits, fed to the decoder and readable |

## Verification
Each policy is driven with the following patterns:

- a repeat of the value already stored;
- a fresh value held for several strobes;
- an interleaved sequence in which a lone outlier breaks a run.

Together these separate transparent reporting from change-only reporting, and show exactly which strobe in a run raises the interrupt. A policy switch placed between two receptions of one value shows whether the count really restarts.

The activation bits are given a level on one bit while another bit's run is broken. This exposes any sharing of counters between bits. Varying msg_i and act_i with no strobe checks that nothing is latched outside the strobe.

// File: rtl/mmv_pkg.sv
package mmv_pkg;
  typedef enum logic [1:0] {
    MODE_PASS   = 2'b00,
    MODE_CHANGE = 2'b01,
    MODE_TWICE  = 2'b10,
    MODE_THRICE = 2'b11
  } mode_e;

  localparam int unsigned MAX_RPT = 3;
  localparam int unsigned CNT_W   = $clog2(MAX_RPT + 1);

  function automatic logic [CNT_W-1:0] need_count(mode_e m);
    case (m)
      MODE_TWICE:  need_count = CNT_W'(2);
      MODE_THRICE: need_count = CNT_W'(3);
      default:     need_count = CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/mmv_persist.sv
// Candidate + saturating repeat counter; cnt_nxt_o is the count this strobe yields.
module mmv_persist #(
  parameter int unsigned W     = 8,
  parameter int unsigned MAX   = 3,
  parameter int unsigned CNT_W = $clog2(MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             restart_i,
  input  logic [W-1:0]     data_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [W-1:0]     cand_q;
  logic [CNT_W-1:0] cnt_q;
  logic             same;

  always_comb begin
    same = (data_i == cand_q) && (cnt_q != '0) && !restart_i;
    if (!same)
      cnt_nxt_o = CNT_W'(1);
    else if (cnt_q == CNT_W'(MAX))
      cnt_nxt_o = cnt_q;
    else
      cnt_nxt_o = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cnt_q  <= '0;
    end else if (stb_i) begin
      cand_q <= data_i;
      cnt_q  <= cnt_nxt_o;
    end else if (restart_i) begin
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/mmv_act_filter.sv
module mmv_act_filter #(
  parameter int unsigned ACT_W   = 4,
  parameter int unsigned PERSIST = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic [ACT_W-1:0] act_i,
  output logic [ACT_W-1:0] act_o
);
  localparam int unsigned PW = $clog2(PERSIST + 1);

  for (genvar i = 0; i < ACT_W; i++) begin : g_bit
    logic [PW-1:0] cnt_nxt;
    logic          val_q;

    mmv_persist #(.W(1), .MAX(PERSIST), .CNT_W(PW)) u_persist (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .stb_i     (stb_i),
      .restart_i (1'b0),
      .data_i    (act_i[i]),
      .cnt_nxt_o (cnt_nxt)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  val_q <= 1'b0;
      else if (stb_i && cnt_nxt == PW'(PERSIST))    val_q <= act_i[i];
    end

    assign act_o[i] = val_q;
  end
endmodule

// File: rtl/mmv_msg_policy.sv
module mmv_msg_policy
  import mmv_pkg::*;
#(
  parameter int unsigned MSG_W = 8
) (
  input  logic             stb_i,
  input  mode_e            mode_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic [MSG_W-1:0] msg_reg_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  output logic             accept_o
);
  always_comb begin
    accept_o = 1'b0;
    if (stb_i) begin
      if (mode_i == MODE_PASS)
        accept_o = 1'b1;
      else
        accept_o = (cnt_nxt_i >= need_count(mode_i)) && (msg_i != msg_reg_i);
    end
  end
endmodule

// File: rtl/maint_msg_validator.sv
module maint_msg_validator
  import mmv_pkg::*;
#(
  parameter int unsigned MSG_W       = 8,
  parameter int unsigned ACT_W       = 4,
  parameter int unsigned ACT_PERSIST = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsf_stb_i,
  input  logic [1:0]       mode_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic [ACT_W-1:0] act_i,
  output logic [MSG_W-1:0] msg_reg_o,
  output logic             msg_irq_o,
  output logic [ACT_W-1:0] act_o
);
  mode_e            mode, mode_q;
  logic             mode_chg;
  logic [CNT_W-1:0] cnt_nxt;
  logic             accept;
  logic [MSG_W-1:0] msg_reg_q;
  logic             irq_q;

  assign mode     = mode_e'(mode_i);
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PASS;
    else         mode_q <= mode;
  end

  mmv_persist #(.W(MSG_W), .MAX(MAX_RPT), .CNT_W(CNT_W)) u_msg_persist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (hsf_stb_i),
    .restart_i (mode_chg),
    .data_i    (msg_i),
    .cnt_nxt_o (cnt_nxt)
  );

  mmv_msg_policy #(.MSG_W(MSG_W)) u_policy (
    .stb_i     (hsf_stb_i),
    .mode_i    (mode),
    .msg_i     (msg_i),
    .msg_reg_i (msg_reg_q),
    .cnt_nxt_i (cnt_nxt),
    .accept_o  (accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_reg_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= accept;
      if (accept) msg_reg_q <= msg_i;
    end
  end

  mmv_act_filter #(.ACT_W(ACT_W), .PERSIST(ACT_PERSIST)) u_act (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (hsf_stb_i),
    .act_i  (act_i),
    .act_o  (act_o)
  );

  assign msg_reg_o = msg_reg_q;
  assign msg_irq_o = irq_q;
endmodule

// File: rtl/mmv_checker.sv
module mmv_checker #(
  parameter int unsigned MSG_W = 8,
  parameter int unsigned ACT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hsf_stb_i,
  input logic [1:0]       mode_i,
  input logic [MSG_W-1:0] msg_i,
  input logic [MSG_W-1:0] msg_reg_o,
  input logic             msg_irq_o,
  input logic [ACT_W-1:0] act_o
);
  assert_irq_after_stb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_irq_o |-> $past(hsf_stb_i));

  assert_reg_moves_with_irq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(msg_reg_o) |-> msg_irq_o);

  assert_pass_reports_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsf_stb_i && mode_i == 2'b00) |=> (msg_irq_o && msg_reg_o == $past(msg_i)));

  assert_filtered_irq_new_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_irq_o && $past(mode_i) != 2'b00) |-> (msg_reg_o != $past(msg_reg_o)));

  assert_act_quiet_no_stb_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsf_stb_i |=> $stable(act_o));
endmodule

bind maint_msg_validator mmv_checker #(.MSG_W(MSG_W), .ACT_W(ACT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hsf_stb_i (hsf_stb_i),
  .mode_i    (mode_i),
  .msg_i     (msg_i),
  .msg_reg_o (msg_reg_o),
  .msg_irq_o (msg_irq_o),
  .act_o     (act_o)
);

// File: tb/maint_msg_validator_test.sv
`timescale 1ns/1ps
module maint_msg_validator_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stb = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] msg = 8'h00;
  logic [3:0] act = 4'h0;
  logic [7:0] msg_reg;
  logic       irq;
  logic [3:0] act_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  maint_msg_validator uut (
    .clk_i(clk), .rst_ni(rst_ni), .hsf_stb_i(stb), .mode_i(mode),
    .msg_i(msg), .act_i(act), .msg_reg_o(msg_reg), .msg_irq_o(irq), .act_o(act_q)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] m);
    @(negedge clk);
    rst_ni = 1'b0; stb = 1'b0; mode = m; msg = 8'h00; act = 4'h0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // one strobe; outputs sampled at the negedge after the capturing edge
  task automatic send(logic [7:0] m, logic [3:0] a);
    stb = 1'b1; msg = m; act = a;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(2'b00);
    chk("R1 msg_reg", msg_reg, 0);
    chk("R1 irq", irq, 0);
    chk("R1 act", act_q, 0);
  endtask

  task automatic t_pass;
    do_reset(2'b00);
    send(8'h5A, 4'h0); chk("R2 irq", irq, 1); chk("R2 reg", msg_reg, 8'h5A);
    @(negedge clk);    chk("R7 pulse one cycle", irq, 0); chk("R7 reg held", msg_reg, 8'h5A);
    send(8'h5A, 4'h0); chk("R2 irq on repeat", irq, 1);
  endtask

  task automatic t_change;
    do_reset(2'b01);
    send(8'h00, 4'h0); chk("R3 same as reset value", irq, 0);
    send(8'h33, 4'h0); chk("R3 irq", irq, 1); chk("R3 reg", msg_reg, 8'h33);
    send(8'h33, 4'h0); chk("R3 repeat silent", irq, 0);
    send(8'h44, 4'h0); chk("R3 new", irq, 1); chk("R3 reg new", msg_reg, 8'h44);
  endtask

  task automatic t_twice;
    do_reset(2'b10);
    send(8'h11, 4'h0); chk("R4 first", irq, 0); chk("R4 reg kept", msg_reg, 0);
    send(8'h11, 4'h0); chk("R4 second", irq, 1); chk("R4 reg", msg_reg, 8'h11);
    send(8'h11, 4'h0); chk("R4 third silent", irq, 0);
    send(8'h22, 4'h0); chk("R6 first 22", irq, 0);
    send(8'h23, 4'h0); chk("R6 outlier", irq, 0);
    send(8'h23, 4'h0); chk("R6 new candidate", irq, 1); chk("R6 reg", msg_reg, 8'h23);
  endtask

  task automatic t_thrice;
    do_reset(2'b11);
    send(8'h7E, 4'h0); chk("R5 first", irq, 0);
    send(8'h7E, 4'h0); chk("R5 second", irq, 0);
    send(8'h7E, 4'h0); chk("R5 third", irq, 1); chk("R5 reg", msg_reg, 8'h7E);
    send(8'h01, 4'h0); send(8'h01, 4'h0); chk("R6 two of three", irq, 0);
    send(8'h02, 4'h0); send(8'h01, 4'h0); send(8'h01, 4'h0);
    chk("R6 broken run", irq, 0); chk("R6 reg kept", msg_reg, 8'h7E);
    send(8'h01, 4'h0); chk("R6 run complete", irq, 1); chk("R6 reg 01", msg_reg, 8'h01);
  endtask

  task automatic t_mode_change;
    do_reset(2'b10);
    send(8'h55, 4'h0); chk("R8 before change", irq, 0);
    mode = 2'b11;
    @(negedge clk);
    send(8'h55, 4'h0); chk("R8 first after change", irq, 0);
    send(8'h55, 4'h0); chk("R8 second after change", irq, 0);
    send(8'h55, 4'h0); chk("R8 third after change", irq, 1); chk("R8 reg", msg_reg, 8'h55);
  endtask

  task automatic t_act;
    do_reset(2'b01);
    send(8'h00, 4'b0101); chk("R9 one", act_q, 0);
    send(8'h00, 4'b0101); chk("R9 two", act_q, 0); chk("R10 irq", irq, 0);
    send(8'h00, 4'b0101); chk("R9 three", act_q, 4'b0101); chk("R10 no irq", irq, 0);
    send(8'h00, 4'b0111); send(8'h00, 4'b0101);
    send(8'h00, 4'b0111); send(8'h00, 4'b0111);
    chk("R9 bit1 pending", act_q, 4'b0101);
    send(8'h00, 4'b0111); chk("R9 bit1 taken", act_q, 4'b0111);
    mode = 2'b00;
    @(negedge clk);
    send(8'h00, 4'b0011); send(8'h00, 4'b0011); send(8'h00, 4'b0011);
    chk("R9 mode independent", act_q, 4'b0011);
  endtask

  task automatic t_idle;
    do_reset(2'b00);
    send(8'h9C, 4'hF); send(8'h9C, 4'hF); send(8'h9C, 4'hF);
    for (int i = 0; i < 6; i++) begin
      msg = 8'(i * 37); act = 4'(i);
      @(negedge clk);
      chk("R11 irq idle", irq, 0);
    end
    chk("R11 reg held", msg_reg, 8'h9C);
    chk("R11 act held", act_q, 4'hF);
  endtask

  initial begin
    t_reset();
    t_pass();
    t_change();
    t_twice();
    t_thrice();
    t_mode_change();
    t_act();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule